// File: doc/BRIEF.md
# SPI Device Bring-Up Sequencer

This block powers up a two-device clocking and conversion chain by walking a fixed list of configuration steps. The list programs a clock generator first. It then waits for that generator's PLL to report lock and lets the clock settle. Next it programs a data converter, waits for the converter's internal calibration loop to converge, and finally reads a calibration status register to decide whether bring-up succeeded. Each step is one of the following: a register write, a read-modify-write, a timed pause, a lock wait with its own timeout, a masked status compare, or the end marker.

Register traffic leaves the block through a level request/acknowledge handshake toward a serial-bus master that is not part of this block. The sequencer enforces a minimum idle gap between transactions. Pause lengths are stored in milliseconds and scaled by a clocks-per-millisecond parameter, so a bench can shorten them without editing the list. A single start pulse launches a run. `busy` covers the run. When the run ends, `done` rises together with exactly one of `pass`, `fail` or `timeout`, and all four hold their values until the next start.

Top module: `bringup_seq`

## Requirements
- R1: While reset is high and after it is released, `busy`, `done`, `pass`, `fail`, `timeout` and `spi_req` are low.
- R2: A `start` pulse while `busy` is low raises `busy` and clears `done`, `pass`, `fail` and `timeout` one cycle later. A `start` while `busy` is high is ignored, and the run goes on unchanged with no repeated transactions.
- R3: Every transaction holds `spi_req` high, with `spi_dev`, `spi_wr`, `spi_addr` and `spi_wdata` stable, until a one-cycle `spi_ack`. `spi_req` is low in the cycle after the acknowledge. `spi_dev` is 0 for the clock generator and 1 for the converter, and `spi_wr` is 1 for a write and 0 for a read.
- R4: A read-modify-write step reads a register and then writes `(read & ~clear_mask) | set_mask` to the same device and address before the next step starts.
- R5: Between the acknowledge of one transaction and the request of the next, at least `GAP_CLKS` clock cycles pass.
- R6: A pause step of N ms stalls the list for at least N·`CLK_PER_MS` cycles and releases it within a few cycles after that.
- R7: All clock-generator transactions come before any converter transaction. No converter transaction starts until `pll_lock` has been seen high through a `SYNC_STAGES` synchronizer.
- R8: If lock is not seen within the lock-wait limit of `LOCK_TMO_MS` ms, the run ends with `done` and `timeout` high, `busy` low, and no further transactions.
- R9: The stored list programs the clock generator with writes to 0x0100 (0x5A) and 0x0101 (0x3C) and an RMW of 0x0102 (set 0x80, clear 0x0F). It then waits for lock and pauses `SETTLE_MS` (223 ms) before the first converter write. On the converter it writes 0x0005 with 0x00 and then 0x40, does an RMW of 0x006D (set 0x40), pauses `HOLD_MS` (1000 ms), does an RMW of 0x006E (set 0x01, clear 0x02), and pauses `CAL_MS` (1600 ms) before reading status at 0x0298.
- R10: The status check passes only when the low four bits of the read value equal 0xE, whatever the upper four bits are. Any other low nibble ends the run with `done` and `fail`.
- R11: At the end of a run `done` rises together with exactly one of `pass`, `fail` or `timeout`, and these four stay unchanged until the next accepted `start`.
- R12: `busy` stays high from an accepted start until the end marker or an error, and `spi_req` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches a run when idle |
| pll_lock | input | 1 | Asynchronous lock indication from the clock generator |
| spi_ack | input | 1 | One-cycle completion strobe from the serial master |
| spi_rdata | input | 8 | Read data, valid with `spi_ack` |
| spi_req | output | 1 | Transaction request, held until acknowledged |
| spi_dev | output | 1 | Target device: 0 clock generator, 1 converter |
| spi_wr | output | 1 | 1 write, 0 read |
| spi_addr | output | 16 | Register address |
| spi_wdata | output | 8 | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Finished with status match |
| fail | output | 1 | Finished with status mismatch |
| timeout | output | 1 | Finished because lock never came |

## Verification
`busy` is due exactly one cycle after an accepted start. The bench samples it at the falling edge that follows the start pulse and checks it there without tolerance. Pauses are due after N·`CLK_PER_MS` cycles plus a fetch-and-issue overhead of a handful of cycles. For them, and for the inter-transaction gap, the bench time-stamps each request and acknowledge at falling edges and checks the distance against a lower bound from the requirement and a small upper window. End-of-run flags are checked once `done` is seen, and then again after a quiet interval to confirm they hold.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

    localparam int MS_W = 16;

    typedef enum logic [2:0] {
        OP_END   = 3'd0,
        OP_WRITE = 3'd1,
        OP_RMW   = 3'd2,
        OP_DELAY = 3'd3,
        OP_LOCK  = 3'd4,
        OP_CHECK = 3'd5
    } op_e;

    typedef enum logic {
        DEV_CLKGEN = 1'b0,
        DEV_CONV   = 1'b1
    } dev_e;

    // val: write data, set mask or expected value; msk: clear mask or compare mask
    typedef struct packed {
        op_e             op;
        dev_e            dev;
        logic [15:0]     addr;
        logic [7:0]      val;
        logic [7:0]      msk;
        logic [MS_W-1:0] ms;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_WAIT,
        ST_DELAY,
        ST_LOCK
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_PLAIN,
        PH_RMW_RD,
        PH_CHECK
    } phase_e;

    function automatic step_t mk_step(op_e op, dev_e dev, logic [15:0] addr,
                                      logic [7:0] val, logic [7:0] msk,
                                      logic [MS_W-1:0] ms);
        step_t s;
        s.op   = op;
        s.dev  = dev;
        s.addr = addr;
        s.val  = val;
        s.msk  = msk;
        s.ms   = ms;
        return s;
    endfunction

    function automatic logic [7:0] rmw_merge(logic [7:0] old, logic [7:0] set_m,
                                             logic [7:0] clr_m);
        return (old & ~clr_m) | set_m;
    endfunction

    function automatic logic status_match(logic [7:0] rd, logic [7:0] cmp_m,
                                          logic [7:0] want);
        return (rd & cmp_m) == (want & cmp_m);
    endfunction

endpackage

// File: rtl/seq_rom.sv
module seq_rom
    import bringup_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int LOCK_TMO_MS = 50,
    parameter int SETTLE_MS   = 223,
    parameter int HOLD_MS     = 1000,
    parameter int CAL_MS      = 1600,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic [AW-1:0] idx,
    output step_t         step
);

    localparam logic [MS_W-1:0] TMO_V    = MS_W'(LOCK_TMO_MS);
    localparam logic [MS_W-1:0] SETTLE_V = MS_W'(SETTLE_MS);
    localparam logic [MS_W-1:0] HOLD_V   = MS_W'(HOLD_MS);
    localparam logic [MS_W-1:0] CAL_V    = MS_W'(CAL_MS);

    always_comb begin
        case (32'(idx))
            // clock generator programming
            0:  step = mk_step(OP_WRITE, DEV_CLKGEN, 16'h0100, 8'h5A, 8'h00, '0);
            1:  step = mk_step(OP_WRITE, DEV_CLKGEN, 16'h0101, 8'h3C, 8'h00, '0);
            2:  step = mk_step(OP_RMW,   DEV_CLKGEN, 16'h0102, 8'h80, 8'h0F, '0);
            // gate on PLL lock, then let the clock settle
            3:  step = mk_step(OP_LOCK,  DEV_CLKGEN, 16'h0000, 8'h00, 8'h00, TMO_V);
            4:  step = mk_step(OP_DELAY, DEV_CLKGEN, 16'h0000, 8'h00, 8'h00, SETTLE_V);
            // converter programming
            5:  step = mk_step(OP_WRITE, DEV_CONV,   16'h0005, 8'h00, 8'h00, '0);
            6:  step = mk_step(OP_WRITE, DEV_CONV,   16'h0005, 8'h40, 8'h00, '0);
            7:  step = mk_step(OP_RMW,   DEV_CONV,   16'h006D, 8'h40, 8'h00, '0);
            8:  step = mk_step(OP_DELAY, DEV_CONV,   16'h0000, 8'h00, 8'h00, HOLD_V);
            9:  step = mk_step(OP_RMW,   DEV_CONV,   16'h006E, 8'h01, 8'h02, '0);
            // calibration settle and status check on the low nibble
            10: step = mk_step(OP_DELAY, DEV_CONV,   16'h0000, 8'h00, 8'h00, CAL_V);
            11: step = mk_step(OP_CHECK, DEV_CONV,   16'h0298, 8'h0E, 8'h0F, '0);
            default: step = mk_step(OP_END, DEV_CLKGEN, 16'h0000, 8'h00, 8'h00, '0);
        endcase
    end

endmodule

// File: rtl/ms_timer.sv
module ms_timer
    import bringup_pkg::*;
#(
    parameter int CLK_PER_MS = 250000,
    localparam int PRE_W     = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [MS_W-1:0] ms_in,
    output logic            expired
);

    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLK_PER_MS - 1);

    logic [MS_W-1:0]  ms_left;
    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_left <= '0;
            pre     <= '0;
        end else if (load) begin
            ms_left <= ms_in;
            pre     <= PRE_TOP;
        end else if (ms_left != '0) begin
            if (pre == '0) begin
                pre     <= PRE_TOP;
                ms_left <= ms_left - 1'b1;
            end else begin
                pre <= pre - 1'b1;
            end
        end
    end

    assign expired = (ms_left == '0);

endmodule

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) ff <= '0;
                else     ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];

endmodule

// File: rtl/bringup_seq.sv
module bringup_seq
    import bringup_pkg::*;
#(
    parameter int CLK_PER_MS  = 250000,
    parameter int GAP_CLKS    = 250,
    parameter int SYNC_STAGES = 2,
    parameter int ROM_DEPTH   = 16,
    parameter int LOCK_TMO_MS = 50,
    parameter int SETTLE_MS   = 223,
    parameter int HOLD_MS     = 1000,
    parameter int CAL_MS      = 1600
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        pll_lock,
    input  logic        spi_ack,
    input  logic [7:0]  spi_rdata,
    output logic        spi_req,
    output logic        spi_dev,
    output logic        spi_wr,
    output logic [15:0] spi_addr,
    output logic [7:0]  spi_wdata,
    output logic        busy,
    output logic        done,
    output logic        pass,
    output logic        fail,
    output logic        timeout
);

    localparam int PC_W  = $clog2(ROM_DEPTH);
    localparam int GAP_W = $clog2(GAP_CLKS + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_CLKS);

    logic [PC_W-1:0]  pc;
    step_t            step;
    logic             lock_s;
    logic             tmr_load;
    logic             tmr_exp;
    seq_state_e       st;
    phase_e           ph;
    logic [7:0]       c_val;
    logic [7:0]       c_msk;
    logic [GAP_W-1:0] gap_cnt;
    logic             gap_ok;

    seq_rom #(
        .DEPTH      (ROM_DEPTH),
        .LOCK_TMO_MS(LOCK_TMO_MS),
        .SETTLE_MS  (SETTLE_MS),
        .HOLD_MS    (HOLD_MS),
        .CAL_MS     (CAL_MS)
    ) u_rom (
        .idx (pc),
        .step(step)
    );

    ms_timer #(
        .CLK_PER_MS(CLK_PER_MS)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .ms_in  (step.ms),
        .expired(tmr_exp)
    );

    sync_chain #(
        .STAGES(SYNC_STAGES)
    ) u_lock_sync (
        .clk(clk),
        .rst(rst),
        .d  (pll_lock),
        .q  (lock_s)
    );

    assign tmr_load = (st == ST_FETCH) && (step.op == OP_DELAY || step.op == OP_LOCK);

    // idle-cycle count since the last acknowledge, saturating at the gap
    always_ff @(posedge clk) begin
        if (rst)                  gap_cnt <= GAP_MAX;
        else if (spi_ack)         gap_cnt <= '0;
        else if (gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
    end

    assign gap_ok = (gap_cnt == GAP_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= PH_PLAIN;
            pc        <= '0;
            c_val     <= '0;
            c_msk     <= '0;
            spi_req   <= 1'b0;
            spi_dev   <= 1'b0;
            spi_wr    <= 1'b0;
            spi_addr  <= '0;
            spi_wdata <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        pc      <= '0;
                        busy    <= 1'b1;
                        done    <= 1'b0;
                        pass    <= 1'b0;
                        fail    <= 1'b0;
                        timeout <= 1'b0;
                        st      <= ST_FETCH;
                    end
                end

                ST_FETCH: begin
                    case (step.op)
                        OP_WRITE: begin
                            spi_dev   <= step.dev;
                            spi_addr  <= step.addr;
                            spi_wr    <= 1'b1;
                            spi_wdata <= step.val;
                            ph        <= PH_PLAIN;
                            st        <= ST_ISSUE;
                        end
                        OP_RMW: begin
                            spi_dev   <= step.dev;
                            spi_addr  <= step.addr;
                            spi_wr    <= 1'b0;
                            spi_wdata <= '0;
                            c_val     <= step.val;
                            c_msk     <= step.msk;
                            ph        <= PH_RMW_RD;
                            st        <= ST_ISSUE;
                        end
                        OP_CHECK: begin
                            spi_dev   <= step.dev;
                            spi_addr  <= step.addr;
                            spi_wr    <= 1'b0;
                            spi_wdata <= '0;
                            c_val     <= step.val;
                            c_msk     <= step.msk;
                            ph        <= PH_CHECK;
                            st        <= ST_ISSUE;
                        end
                        OP_DELAY: st <= ST_DELAY;
                        OP_LOCK:  st <= ST_LOCK;
                        default: begin
                            busy <= 1'b0;
                            done <= 1'b1;
                            pass <= 1'b1;
                            st   <= ST_IDLE;
                        end
                    endcase
                end

                ST_ISSUE: begin
                    if (gap_ok) begin
                        spi_req <= 1'b1;
                        st      <= ST_WAIT;
                    end
                end

                ST_WAIT: begin
                    if (spi_ack) begin
                        spi_req <= 1'b0;
                        case (ph)
                            PH_RMW_RD: begin
                                spi_wdata <= rmw_merge(spi_rdata, c_val, c_msk);
                                spi_wr    <= 1'b1;
                                ph        <= PH_PLAIN;
                                st        <= ST_ISSUE;
                            end
                            PH_CHECK: begin
                                if (status_match(spi_rdata, c_msk, c_val)) begin
                                    pc <= pc + 1'b1;
                                    st <= ST_FETCH;
                                end else begin
                                    busy <= 1'b0;
                                    done <= 1'b1;
                                    fail <= 1'b1;
                                    st   <= ST_IDLE;
                                end
                            end
                            default: begin
                                pc <= pc + 1'b1;
                                st <= ST_FETCH;
                            end
                        endcase
                    end
                end

                ST_DELAY: begin
                    if (tmr_exp) begin
                        pc <= pc + 1'b1;
                        st <= ST_FETCH;
                    end
                end

                ST_LOCK: begin
                    if (lock_s) begin
                        pc <= pc + 1'b1;
                        st <= ST_FETCH;
                    end else if (tmr_exp) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        timeout <= 1'b1;
                        st      <= ST_IDLE;
                    end
                end

                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bringup_seq_chk.sv
module bringup_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        pll_lock,
    input logic        spi_ack,
    input logic        spi_req,
    input logic        spi_dev,
    input logic        spi_wr,
    input logic [15:0] spi_addr,
    input logic [7:0]  spi_wdata,
    input logic        busy,
    input logic        done,
    input logic        pass,
    input logic        fail,
    input logic        timeout
);

    logic lock_seen;

    always_ff @(posedge clk) begin
        if (rst)                 lock_seen <= 1'b0;
        else if (start && !busy) lock_seen <= 1'b0;
        else if (pll_lock)       lock_seen <= 1'b1;
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_addr) && $stable(spi_wr)
                                   && $stable(spi_wdata) && $stable(spi_dev)));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        spi_ack |=> !spi_req);

    // R12
    req_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        spi_req |-> busy);

    // R7
    conv_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_req && spi_dev) |-> lock_seen);

    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pass, fail, timeout}) && (done == (pass || fail || timeout)));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> (!busy && $stable(done) && $stable(pass)
                               && $stable(fail) && $stable(timeout)));

    // R8
    timeout_end_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (done && !busy && !spi_req));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));

endmodule

bind bringup_seq bringup_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pll_lock (pll_lock),
    .spi_ack  (spi_ack),
    .spi_req  (spi_req),
    .spi_dev  (spi_dev),
    .spi_wr   (spi_wr),
    .spi_addr (spi_addr),
    .spi_wdata(spi_wdata),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .fail     (fail),
    .timeout  (timeout)
);

// File: tb/test_bringup_seq.sv
module test_bringup_seq;

    localparam int P    = 4;
    localparam int GAP  = 5;
    localparam int LAT  = 3;
    localparam int LOGN = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        pll_lock = 1'b1;
    logic        spi_ack;
    logic [7:0]  spi_rdata;
    logic        spi_req, spi_dev, spi_wr;
    logic [15:0] spi_addr;
    logic [7:0]  spi_wdata;
    logic        busy, done, pass, fail, timeout;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_log = 0;
    int done_cyc = 0;
    logic [7:0] cal_val = 8'h3E;

    logic        l_dev   [LOGN];
    logic        l_wr    [LOGN];
    logic [15:0] l_addr  [LOGN];
    logic [7:0]  l_wdata [LOGN];
    int          l_start [LOGN];
    int          l_end   [LOGN];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bringup_seq #(
        .CLK_PER_MS (P),
        .GAP_CLKS   (GAP),
        .SYNC_STAGES(2)
    ) i_bringup_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pll_lock (pll_lock),
        .spi_ack  (spi_ack),
        .spi_rdata(spi_rdata),
        .spi_req  (spi_req),
        .spi_dev  (spi_dev),
        .spi_wr   (spi_wr),
        .spi_addr (spi_addr),
        .spi_wdata(spi_wdata),
        .busy     (busy),
        .done     (done),
        .pass     (pass),
        .fail     (fail),
        .timeout  (timeout)
    );

    function automatic logic [7:0] rd_model(logic dev, logic [15:0] a);
        if (dev && a == 16'h0298) return cal_val;
        if (dev && a == 16'h006D) return 8'h12;
        if (dev && a == 16'h006E) return 8'h06;
        if (!dev && a == 16'h0102) return 8'hF3;
        return 8'h00;
    endfunction

    // serial master model: acknowledges LAT falling edges after a request
    initial begin
        int lat;
        int s_cyc;
        lat = 0;
        s_cyc = 0;
        spi_ack = 1'b0;
        spi_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (spi_ack) begin
                spi_ack = 1'b0;
                lat = 0;
            end else if (spi_req) begin
                if (lat == 0) s_cyc = cyc;
                if (lat == LAT) begin
                    spi_ack = 1'b1;
                    spi_rdata = rd_model(spi_dev, spi_addr);
                    if (n_log < LOGN) begin
                        l_dev[n_log]   = spi_dev;
                        l_wr[n_log]    = spi_wr;
                        l_addr[n_log]  = spi_addr;
                        l_wdata[n_log] = spi_wdata;
                        l_start[n_log] = s_cyc;
                        l_end[n_log]   = cyc;
                    end
                    n_log = n_log + 1;
                end else begin
                    lat = lat + 1;
                end
            end
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic check_range(input string rq, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", rq, act, lo, hi);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int max);
        for (int k = 0; k < max; k++) begin
            @(negedge clk);
            if (done) begin
                done_cyc = cyc;
                return;
            end
        end
        check("R12 run did not finish", 32'(done), 32'd1);
    endtask

    task automatic expect_txn(input int i, input logic dev, input logic wr,
                              input logic [15:0] a, input logic [7:0] d);
        logic [7:0] dw;
        dw = wr ? l_wdata[i] : 8'h00;
        check($sformatf("R9 transaction %0d", i),
              {14'd0, l_dev[i], l_wr[i], l_addr[i]}, {14'd0, dev, wr, a});
        if (wr) check($sformatf("R4 write data of transaction %0d", i), 32'(dw), 32'(d));
    endtask

    task automatic check_full_list();
        check("R9 transaction count", n_log, 11);
        expect_txn(0, 1'b0, 1'b1, 16'h0100, 8'h5A);
        expect_txn(1, 1'b0, 1'b1, 16'h0101, 8'h3C);
        expect_txn(2, 1'b0, 1'b0, 16'h0102, 8'h00);
        expect_txn(3, 1'b0, 1'b1, 16'h0102, 8'hF0);
        expect_txn(4, 1'b1, 1'b1, 16'h0005, 8'h00);
        expect_txn(5, 1'b1, 1'b1, 16'h0005, 8'h40);
        expect_txn(6, 1'b1, 1'b0, 16'h006D, 8'h00);
        expect_txn(7, 1'b1, 1'b1, 16'h006D, 8'h52);
        expect_txn(8, 1'b1, 1'b0, 16'h006E, 8'h00);
        expect_txn(9, 1'b1, 1'b1, 16'h006E, 8'h05);
        expect_txn(10, 1'b1, 1'b0, 16'h0298, 8'h00);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R1
        check("R1 outputs in reset", {27'd0, busy, done, pass, fail, timeout}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 outputs after reset", {26'd0, spi_req, busy, done, pass, fail, timeout}, 32'd0);
    endtask

    task automatic t_pass_run();
        pll_lock = 1'b1;
        cal_val = 8'h3E;
        n_log = 0;
        pulse_start();
        // R2: busy one cycle after start
        check("R2 busy after start", {30'd0, busy, done}, 32'd2);
        for (int k = 0; k < 20000 && n_log < 8; k++) @(negedge clk);
        // R2: second start during the run is ignored
        pulse_start();
        check("R12 busy during run", 32'(busy), 32'd1);
        wait_done(20000);
        check("R10 pass result", {28'd0, done, pass, fail, timeout}, 32'b1100);
        check_full_list();
        for (int i = 1; i < 11; i++)
            check_range("R5 gap between transactions", l_start[i] - l_end[i-1], GAP, 1000000);
        check_range("R9 settle before converter", l_start[4] - l_end[3], 223 * P, 223 * P + 20);
        check_range("R6 hold pause", l_start[8] - l_end[7], 1000 * P, 1000 * P + 20);
        check_range("R9 calibration wait", l_start[10] - l_end[9], 1600 * P, 1600 * P + 20);
        repeat (50) @(negedge clk);
        check("R11 result held", {27'd0, busy, done, pass, fail, timeout}, 32'b01100);
    endtask

    task automatic t_cal_fail_and_restart();
        pll_lock = 1'b1;
        cal_val = 8'hFD;
        n_log = 0;
        pulse_start();
        wait_done(20000);
        check("R10 fail on low nibble 0xD", {28'd0, done, pass, fail, timeout}, 32'b1010);
        check("R10 fail run transaction count", n_log, 11);
        repeat (40) @(negedge clk);
        check("R11 fail held", {27'd0, busy, done, pass, fail, timeout}, 32'b01010);
        check("R10 no traffic after fail", n_log, 11);
        // restart clears the result
        cal_val = 8'hFE;
        n_log = 0;
        pulse_start();
        check("R2 restart clears result", {27'd0, busy, done, pass, fail, timeout}, 32'b10000);
        wait_done(20000);
        check("R10 upper nibble ignored", {28'd0, done, pass, fail, timeout}, 32'b1100);
    endtask

    task automatic t_late_lock();
        int lock_cyc;
        pll_lock = 1'b0;
        cal_val = 8'h0E;
        n_log = 0;
        pulse_start();
        for (int k = 0; k < 2000 && n_log < 4; k++) @(negedge clk);
        repeat (100) @(negedge clk);
        check("R7 no converter traffic before lock", n_log, 4);
        check("R7 still busy waiting for lock", 32'(busy), 32'd1);
        pll_lock = 1'b1;
        lock_cyc = cyc;
        wait_done(20000);
        check("R7 pass after late lock", {28'd0, done, pass, fail, timeout}, 32'b1100);
        check_range("R7 converter waits for lock plus settle", l_start[4] - lock_cyc,
                    223 * P, 223 * P + 30);
        check("R7 first converter device", 32'(l_dev[4]), 32'd1);
    endtask

    task automatic t_lock_timeout();
        pll_lock = 1'b0;
        n_log = 0;
        pulse_start();
        wait_done(3000);
        check("R8 timeout result", {27'd0, busy, done, pass, fail, timeout}, 32'b01001);
        check("R8 transactions before timeout", n_log, 4);
        check_range("R8 timeout delay", done_cyc - l_end[3], 50 * P, 50 * P + 20);
        repeat (60) @(negedge clk);
        check("R8 no traffic after timeout", n_log, 4);
        check("R11 timeout held", {27'd0, busy, done, pass, fail, timeout}, 32'b01001);
        pll_lock = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_pass_run();
        t_cal_fail_and_restart();
        t_late_lock();
        t_lock_timeout();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule